// File: doc/BRIEF.md
# Configurable Multiplexed Bus Demultiplexer

This block sits between a microcontroller and the internal logic of a memory-and-logic companion device. The controller presents one byte of address on the shared address/data pins, marked by the address latch strobe. The remaining address bits arrive on a separate group of address pins. The controller also drives active-low write, read and program-store-enable strobes. The block rebuilds a full-width address, produces active-high internal write and read strobes, passes write data through to the core, and drives read data back onto the shared pins while a read is in progress.

A static two-bit configuration input selects one of four bus arrangements. The arrangements differ in two ways: which address byte shares the data pins (the low byte in the non-page arrangements, the high byte in the page arrangements), and whether a dedicated read pin is honoured alongside program-store-enable. The shared byte is held by a transparent capture stage. It follows the pins while the latch strobe is high and keeps the value from the last clock edge at which the strobe was high. A synchronous reset clears the stored byte.

Top module: `mux_bus_demux`

## Requirements
- R1: At every rising clock edge with `ale` high and `rst` low, the stored address byte takes the value on `ad_in`. While `ale` is high, the shared-pin byte inside `addr_out` equals the current `ad_in` (transparent).
- R2: While `ale` is low, the shared-pin byte inside `addr_out` equals the byte stored at the last rising edge with `ale` high, whatever `ad_in` does.
- R3: A rising edge with `rst` high clears the stored address byte to zero. A later `ale`-low cycle then shows zero in the shared-pin byte.
- R4: With `cfg_mode` = 2'b00 or 2'b01 (non-page), `addr_out[7:0]` is the shared-pin byte and `addr_out[15:8]` equals `addr_side`.
- R5: With `cfg_mode` = 2'b10 or 2'b11 (page), `addr_out[15:8]` is the shared-pin byte and `addr_out[7:0]` equals `addr_side`.
- R6: In every mode, `int_wr` is high exactly when `wr_n` is low.
- R7: With `cfg_mode` = 2'b00 or 2'b11, `int_rd` is high exactly when `rd_n` is low or `psen_n` is low.
- R8: With `cfg_mode` = 2'b01 or 2'b10, `int_rd` is high exactly when `psen_n` is low, and `rd_n` has no effect on `int_rd`, `ad_oe` or `ad_out`.
- R9: `ad_oe` is high exactly when `int_rd` is high and `ale` is low. While it is high, `ad_out` equals `rd_data`. While it is low, `ad_out` is all zeros.
- R10: `wr_data` always equals `ad_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address capture register |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Bus arrangement: 00 non-page dual read, 01 non-page psen-only, 10 page psen-only, 11 page dual read |
| ad_in | input | 8 | Value seen on the shared address/data pins |
| addr_side | input | 8 | Separate address pins (the byte not multiplexed) |
| ale | input | 1 | Address latch strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Dedicated read strobe, active low |
| psen_n | input | 1 | Program-store-enable strobe, active low |
| rd_data | input | 8 | Read data from the core |
| addr_out | output | 16 | Demultiplexed address |
| int_wr | output | 1 | Internal write strobe, active high |
| int_rd | output | 1 | Internal read strobe, active high |
| wr_data | output | 8 | Write data toward the core |
| ad_out | output | 8 | Value to drive on the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |

## Verification
The bench builds the block with its default widths: an 8-bit shared byte and a 16-bit address. With these widths the two address halves are equal, so a byte in the wrong half is visible at once in every mode. All four `cfg_mode` values are swept at run time with random strobe and pin activity. This exercises the honoured and ignored read-pin cases, and it exercises the overlap of a read strobe with `ale` high, where the pins must stay undriven. Reset is asserted in the middle of the run with `ale` low, so the cleared byte shows through `addr_out`.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

   typedef enum logic [1:0] {
      CFG_LO_DUAL = 2'b00,
      CFG_LO_PSEN = 2'b01,
      CFG_HI_PSEN = 2'b10,
      CFG_HI_DUAL = 2'b11
   } bus_cfg_e;

   function automatic logic cfg_is_paged(bus_cfg_e c);
      return (c == CFG_HI_PSEN) || (c == CFG_HI_DUAL);
   endfunction

   function automatic logic cfg_has_rd_pin(bus_cfg_e c);
      return (c == CFG_LO_DUAL) || (c == CFG_HI_DUAL);
   endfunction

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale,
   input  logic [DATA_W-1:0] pins_in,
   output logic [DATA_W-1:0] byte_out
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mbd_addr_latch: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (ale)
         hold_q <= pins_in;
   end

   // transparent while the strobe is high, frozen once it falls
   always_comb begin
      byte_out = ale ? pins_in : hold_q;
   end

   // R1
   capture_on_ale_chk: assert property (@(posedge clk) disable iff (rst)
      ale |=> (hold_q == $past(pins_in)));

   // R2
   hold_when_low_chk: assert property (@(posedge clk) disable iff (rst)
      !ale |=> $stable(hold_q));

   // R3
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (hold_q == '0));

endmodule

// File: rtl/mbd_addr_merge.sv
module mbd_addr_merge #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  mbd_pkg::bus_cfg_e          cfg,
   input  logic [DATA_W-1:0]          mux_byte,
   input  logic [ADDR_W-DATA_W-1:0]   side_bits,
   output logic [ADDR_W-1:0]          addr
);

   localparam int SIDE_W = ADDR_W - DATA_W;

   generate
      if (SIDE_W < 1) begin : g_bad_split
         $error("mbd_addr_merge: ADDR_W must exceed DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] page_addr;
   logic [ADDR_W-1:0] flat_addr;

   // page arrangement: shared byte on top; otherwise shared byte at bottom
   assign page_addr = {mux_byte, side_bits};
   assign flat_addr = {side_bits, mux_byte};

   always_comb begin
      addr = mbd_pkg::cfg_is_paged(cfg) ? page_addr : flat_addr;
   end

endmodule

// File: rtl/mbd_strobe_map.sv
module mbd_strobe_map (
   input  logic              clk,
   input  logic              rst,
   input  mbd_pkg::bus_cfg_e cfg,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              psen_n,
   output logic              int_wr,
   output logic              int_rd
);

   logic rd_pin_used;

   always_comb begin
      rd_pin_used = mbd_pkg::cfg_has_rd_pin(cfg);
      int_wr      = ~wr_n;
      int_rd      = ~psen_n | (rd_pin_used & ~rd_n);
   end

   // R8
   rd_pin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (!mbd_pkg::cfg_has_rd_pin(cfg) && psen_n) |-> !int_rd);

   // R7
   dual_read_chk: assert property (@(posedge clk) disable iff (rst)
      (mbd_pkg::cfg_has_rd_pin(cfg) && !rd_n) |-> int_rd);

endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [1:0]               cfg_mode,
   input  logic [DATA_W-1:0]        ad_in,
   input  logic [ADDR_W-DATA_W-1:0] addr_side,
   input  logic                     ale,
   input  logic                     wr_n,
   input  logic                     rd_n,
   input  logic                     psen_n,
   input  logic [DATA_W-1:0]        rd_data,
   output logic [ADDR_W-1:0]        addr_out,
   output logic                     int_wr,
   output logic                     int_rd,
   output logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe
);

   mbd_pkg::bus_cfg_e cfg;
   logic [DATA_W-1:0] mux_byte;

   assign cfg = mbd_pkg::bus_cfg_e'(cfg_mode);

   mbd_addr_latch #(.DATA_W(DATA_W)) u_latch (
      .clk      (clk),
      .rst      (rst),
      .ale      (ale),
      .pins_in  (ad_in),
      .byte_out (mux_byte)
   );

   mbd_addr_merge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_merge (
      .cfg       (cfg),
      .mux_byte  (mux_byte),
      .side_bits (addr_side),
      .addr      (addr_out)
   );

   mbd_strobe_map u_strobes (
      .clk    (clk),
      .rst    (rst),
      .cfg    (cfg),
      .wr_n   (wr_n),
      .rd_n   (rd_n),
      .psen_n (psen_n),
      .int_wr (int_wr),
      .int_rd (int_rd)
   );

   // pins are turned around only outside the address phase
   always_comb begin
      ad_oe   = int_rd & ~ale;
      ad_out  = ad_oe ? rd_data : '0;
      wr_data = ad_in;
   end

   // R9
   no_drive_in_addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
      ale |-> !ad_oe);

   // R9
   quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
      (psen_n && rd_n) |-> (!ad_oe && ad_out == '0));

endmodule

// File: tb/tb_mux_bus_demux.sv
module tb_mux_bus_demux;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cfg_mode = 2'b00;
   logic [DW-1:0] ad_in = '0;
   logic [DW-1:0] addr_side = '0;
   logic          ale = 1'b0;
   logic          wr_n = 1'b1;
   logic          rd_n = 1'b1;
   logic          psen_n = 1'b1;
   logic [DW-1:0] rd_data = '0;
   logic [AW-1:0] addr_out;
   logic          int_wr, int_rd, ad_oe;
   logic [DW-1:0] wr_data, ad_out;

   int tests = 0;
   int fails = 0;
   bit done  = 0;
   int ref_hold = 0;   // model of the stored byte
   int rst_seen = 0;   // set after a reset, cleared by the next capture

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_demux #(.DATA_W(DW), .ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .ad_in(ad_in),
      .addr_side(addr_side), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
      .psen_n(psen_n), .rd_data(rd_data), .addr_out(addr_out),
      .int_wr(int_wr), .int_rd(int_rd), .wr_data(wr_data),
      .ad_out(ad_out), .ad_oe(ad_oe)
   );

   always @(posedge clk) begin
      if (rst) begin
         ref_hold <= 0;
         rst_seen <= 1;
      end else if (ale) begin
         ref_hold <= int'(ad_in);
         rst_seen <= 0;
      end
   end

   task automatic check(string tag, int actual, int expected);
      tests++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (mode=%0d t=%0t)",
                  tag, actual, expected, cfg_mode, $time);
      end
   endtask

   task automatic compare_all();
      int  byte_exp, addr_exp, rd_exp, oe_exp, out_exp;
      bit  paged, dual;
      string byte_tag, half_tag;
      paged    = cfg_mode[1];
      dual     = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);
      byte_exp = ale ? int'(ad_in) : ref_hold;
      byte_tag = ale ? "R1" : (rst_seen != 0 ? "R3" : "R2");
      half_tag = paged ? "R5" : "R4";
      if (paged) begin
         addr_exp = (byte_exp << 8) | int'(addr_side);
         check(byte_tag, int'(addr_out[15:8]), byte_exp);
      end else begin
         addr_exp = (int'(addr_side) << 8) | byte_exp;
         check(byte_tag, int'(addr_out[7:0]), byte_exp);
      end
      check(half_tag, int'(addr_out), addr_exp);
      check("R6", int'(int_wr), int'(!wr_n));
      rd_exp = int'(!psen_n || (dual && !rd_n));
      check(dual ? "R7" : "R8", int'(int_rd), rd_exp);
      oe_exp  = int'(rd_exp != 0 && !ale);
      out_exp = (oe_exp != 0) ? int'(rd_data) : 0;
      check("R9", int'(ad_oe), oe_exp);
      check("R9", int'(ad_out), out_exp);
      check("R10", int'(wr_data), int'(ad_in));
   endtask

   // drive after the falling edge, compare a quarter period later
   task automatic step(bit r, bit a, bit w, bit rd, bit ps, logic [DW-1:0] pins);
      @(negedge clk);
      rst = r; ale = a; wr_n = w; rd_n = rd; psen_n = ps; ad_in = pins;
      addr_side = DW'($urandom);
      rd_data   = DW'($urandom);
      #(CLK_PERIOD/4);
      compare_all();
   endtask

   initial begin
      void'($urandom(32'h5eed));
      // reset state
      step(1, 0, 1, 1, 1, 8'h3c);
      step(1, 0, 1, 1, 1, 8'h3c);
      step(0, 0, 1, 1, 1, 8'ha5);   // R3: cleared byte visible
      for (int m = 0; m < 4; m++) begin
         cfg_mode = 2'(m);
         // directed: capture, then pins move while strobe low (R1, R2)
         step(0, 1, 1, 1, 1, 8'h5a);
         step(0, 0, 1, 1, 1, 8'hff);
         // directed: dedicated read pin alone (R7 or R8)
         step(0, 0, 1, 0, 1, 8'h00);
         // directed: read strobe during address phase (R9)
         step(0, 1, 1, 1, 0, 8'h81);
         step(0, 0, 0, 1, 1, 8'h42);
         for (int i = 0; i < 300; i++) begin
            step(0, bit'($urandom), bit'($urandom), bit'($urandom),
                 bit'($urandom), DW'($urandom));
         end
         // mid-run reset with strobe low (R3)
         step(1, 0, 1, 1, 1, 8'h77);
         step(0, 0, 1, 0, 1, 8'h99);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule